// File: doc/BRIEF.md
# Character LCD host bus interface

This block is the register interface that a microcontroller sees on a character LCD controller. The host drives a strobe together with a register-select line, a read/write line and an 8-bit data bus. Through it, the host writes instructions, writes and reads display bytes, and polls a combined status byte that carries the busy flag and the current address. The block holds two internal memories: an 80-byte display-data store and a 64-byte character-pattern store. A data-register write commits the byte to whichever store the address counter currently targets. Data-register reads are answered from a byte that was fetched in advance.

The only instructions decoded here are the two address-set commands. Every other instruction code still makes the block busy, but has no further effect. The address counter steps after each data access, and it wraps inside the range of the store it points at. The host can work with a full byte per strobe or with a 4-bit bus. In 4-bit mode every byte takes two strobes, high nibble first, on the upper four data lines. The step direction and the bus width are static configuration inputs.

Top module: `lcd_host_if`

## Requirements
- R1: `reg_sel`/`rd_wr` select the access as follows: 0/0 writes an instruction, 0/1 reads status, 1/0 writes data, 1/1 reads data. An access takes effect at the falling edge of `bus_stb`, using the values held while the strobe was high. An instruction can never be read back.
- R2: A status read returns the busy flag on bit 7. When the block is not busy, bits 6:0 hold the address counter. While busy, bits 6:0 read as zero.
- R3: Each accepted instruction write or data write holds busy high for `BUSY_CYCLES` clock cycles. Instruction writes and data writes that complete while busy are dropped: no store, no counter step, no address change.
- R4: An instruction with bit 7 set targets the display store and loads bits 6:0 into the address counter. A value above 0x4F loads 0x00. The addressed display byte is then fetched into the data register.
- R5: An instruction with bits 7:6 = 01 targets the character store and loads bits 5:0 into the address counter. The addressed pattern byte is then fetched into the data register.
- R6: A data write stores the byte at the counter address of the targeted store. The counter then steps by one: up when `step_up` is 1, down when it is 0.
- R7: A data read returns the byte held in the data register. The counter then steps by one, and the byte at the new address is fetched for the next read.
- R8: Display addresses wrap from 0x4F to 0x00 when stepping up, and from 0x00 to 0x4F when stepping down.
- R9: Character-store addresses wrap within 6 bits, between 0x3F and 0x00.
- R10: With `nibble_mode` = 1, a byte is two strobes on `bus_din[7:4]`, high nibble first, and `bus_din[3:0]` is ignored. A read returns the matching nibble of the byte on `bus_dout[7:4]`, with `bus_dout[3:0]` = 0.
- R11: With `nibble_mode` = 0, the nibble phase is held at "high nibble next". A half-finished 4-bit transfer is therefore discarded once a full-byte access follows.
- R12: An instruction that is neither address-set form sets busy but leaves the address counter and the store target unchanged.
- R13: After reset the counter is 0x00 and targets the display store, busy is clear, the data register is 0x00 and both stores read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_stb | input | 1 | Host access strobe; access completes on its falling edge |
| reg_sel | input | 1 | 1 = data register, 0 = instruction/status |
| rd_wr | input | 1 | 1 = read, 0 = write |
| bus_din | input | 8 | Host write data (upper nibble only in 4-bit mode) |
| bus_dout | output | 8 | Read data for the access currently selected |
| nibble_mode | input | 1 | 1 = 4-bit bus, 0 = 8-bit bus |
| step_up | input | 1 | Address step direction: 1 = increment, 0 = decrement |

## Verification
On every cycle, the assertions check the following: the strobe edge detector gives single pulses, the display address stays in range, the counter steps and wraps correctly in both stores, address-set loads the counter, busy persists while counting, and a write dropped while busy leaves the address alone. Other behaviour is only visible across whole host transactions, so the bench's scenarios are needed to show it. This covers the prefetched read values, the contents written into either store, the nibble ordering and phase recovery in 4-bit mode, and the status byte that the host actually observes.

// File: rtl/lcd_host_pkg.sv
package lcd_host_pkg;

   // access kind, encoded as {reg_sel, rd_wr}
   typedef enum logic [1:0] {
      ACC_INS_WR  = 2'b00,
      ACC_STAT_RD = 2'b01,
      ACC_DAT_WR  = 2'b10,
      ACC_DAT_RD  = 2'b11
   } acc_e;

   typedef struct packed {
      acc_e       kind;
      logic [7:0] val;
   } bus_xfer_t;

   typedef enum logic [1:0] {
      INS_DD_SET,
      INS_CG_SET,
      INS_OTHER
   } ins_e;

   function automatic ins_e ins_class(input logic [7:0] code);
      if (code[7])
         return INS_DD_SET;
      else if (code[6])
         return INS_CG_SET;
      else
         return INS_OTHER;
   endfunction

endpackage

// File: rtl/lcd_bus_sync.sv
module lcd_bus_sync
   import lcd_host_pkg::*;
#(
   parameter int STAGES = 3
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stb,
   input  logic [1:0] sel,
   input  logic [7:0] din,
   output logic       xfer_valid,
   output bus_xfer_t  xfer
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 3) begin : g_bad_stages
      $error("lcd_bus_sync: STAGES must be at least 3");
   end

   logic [LAST:0]      stb_q;
   logic [LAST:0][1:0] sel_q;
   logic [LAST:0][7:0] dat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_q <= '0;
         sel_q <= '0;
         dat_q <= '0;
      end else begin
         stb_q <= {stb_q[LAST-1:0], stb};
         sel_q <= {sel_q[LAST-1:0], sel};
         dat_q <= {dat_q[LAST-1:0], din};
      end
   end

   // oldest stage still saw the strobe high: its bus values are the ones held
   assign xfer_valid = stb_q[LAST] & ~stb_q[LAST-1];
   assign xfer.kind  = acc_e'(sel_q[LAST]);
   assign xfer.val   = dat_q[LAST];

   a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |=> !xfer_valid);

endmodule

// File: rtl/lcd_nibble_pack.sv
module lcd_nibble_pack
   import lcd_host_pkg::*;
#(
   parameter bit NIBBLE_EN = 1'b1
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      four_bit,
   input  logic      in_valid,
   input  bus_xfer_t in_xfer,
   output logic      out_valid,
   output bus_xfer_t out_xfer,
   output logic      low_next
);

   if (NIBBLE_EN) begin : g_nib
      logic       ph_q;
      logic [3:0] hi_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ph_q <= 1'b0;
            hi_q <= '0;
         end else if (!four_bit) begin
            ph_q <= 1'b0;
         end else if (in_valid) begin
            if (!ph_q)
               hi_q <= in_xfer.val[7:4];
            ph_q <= ~ph_q;
         end
      end

      always_comb begin
         out_xfer  = in_xfer;
         out_valid = 1'b0;
         if (!four_bit) begin
            out_valid = in_valid;
         end else if (in_valid && ph_q) begin
            out_valid    = 1'b1;
            out_xfer.val = {hi_q, in_xfer.val[7:4]};
         end
      end

      assign low_next = ph_q;

      a_r10_first_half: assert property (@(posedge clk) disable iff (!rst_n)
         (four_bit && in_valid && !ph_q) |-> !out_valid);
      a_r11_phase_home: assert property (@(posedge clk) disable iff (!rst_n)
         (!four_bit && in_valid) |=> !low_next);
   end else begin : g_byte
      assign out_valid = in_valid;
      assign out_xfer  = in_xfer;
      assign low_next  = 1'b0;
   end

endmodule

// File: rtl/lcd_addr_ctr.sv
module lcd_addr_ctr #(
   parameter int AC_W     = 7,
   parameter int DD_DEPTH = 80,
   parameter int CG_DEPTH = 64
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            load_cg,
   input  logic [AC_W-1:0] load_val,
   input  logic            step,
   input  logic            up,
   output logic [AC_W-1:0] ac,
   output logic            is_cg
);

   localparam int CG_AW = $clog2(CG_DEPTH);
   localparam logic [AC_W-1:0] DD_TOP = AC_W'(DD_DEPTH - 1);

   logic [CG_AW-1:0] cg_next;
   logic [AC_W-1:0]  dd_next;

   always_comb begin
      cg_next = up ? ac[CG_AW-1:0] + 1'b1 : ac[CG_AW-1:0] - 1'b1;
      if (up)
         dd_next = (ac == DD_TOP) ? '0 : ac + 1'b1;
      else
         dd_next = (ac == '0) ? DD_TOP : ac - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ac    <= '0;
         is_cg <= 1'b0;
      end else if (load) begin
         ac    <= load_val;
         is_cg <= load_cg;
      end else if (step) begin
         ac <= is_cg ? AC_W'(cg_next) : dd_next;
      end
   end

   a_r8_dd_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      !is_cg |-> (ac <= DD_TOP));
   a_r6_dd_step_up: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && up && !is_cg && ac != DD_TOP) |=> (ac == $past(ac) + 1'b1));
   a_r8_dd_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && up && !is_cg && ac == DD_TOP) |=> (ac == '0));
   a_r8_dd_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !up && !is_cg && ac == '0) |=> (ac == DD_TOP));
   a_r9_cg_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !up && is_cg) |=>
         (ac[CG_AW-1:0] == CG_AW'($past(ac[CG_AW-1:0]) - 1'b1)));

endmodule

// File: rtl/lcd_byte_ram.sv
module lcd_byte_ram #(
   parameter int DEPTH = 80,
   parameter int AW    = 7
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);

   if ((1 << AW) < DEPTH) begin : g_bad_aw
      $error("lcd_byte_ram: AW too narrow for DEPTH");
   end

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            mem[i] <= '0;
      end else if (we && (int'(addr) < DEPTH)) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata = (int'(addr) < DEPTH) ? mem[addr] : 8'h00;

endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if
   import lcd_host_pkg::*;
#(
   parameter int DD_DEPTH    = 80,
   parameter int CG_DEPTH    = 64,
   parameter int AC_W        = 7,
   parameter int BUSY_CYCLES = 16,
   parameter bit NIBBLE_EN   = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_stb,
   input  logic       reg_sel,
   input  logic       rd_wr,
   input  logic [7:0] bus_din,
   output logic [7:0] bus_dout,
   input  logic       nibble_mode,
   input  logic       step_up
);

   localparam int DD_AW = $clog2(DD_DEPTH);
   localparam int CG_AW = $clog2(CG_DEPTH);
   localparam int BW    = $clog2(BUSY_CYCLES + 1);

   if (DD_AW > AC_W) begin : g_bad_dd
      $error("lcd_host_if: display depth exceeds address counter");
   end
   if (CG_AW >= AC_W) begin : g_bad_cg
      $error("lcd_host_if: pattern store must be narrower than the counter");
   end
   if (CG_DEPTH != (1 << CG_AW)) begin : g_bad_cgpow
      $error("lcd_host_if: pattern depth must be a power of two");
   end
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("lcd_host_if: BUSY_CYCLES must be positive");
   end

   // ---------------- bus capture ----------------
   logic      raw_v;
   bus_xfer_t raw_x;
   logic      evt;
   bus_xfer_t ex;
   logic      low_next;

   lcd_bus_sync #(.STAGES(3)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .stb        (bus_stb),
      .sel        ({reg_sel, rd_wr}),
      .din        (bus_din),
      .xfer_valid (raw_v),
      .xfer       (raw_x)
   );

   lcd_nibble_pack #(.NIBBLE_EN(NIBBLE_EN)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .four_bit  (nibble_mode),
      .in_valid  (raw_v),
      .in_xfer   (raw_x),
      .out_valid (evt),
      .out_xfer  (ex),
      .low_next  (low_next)
   );

   // ---------------- access decode ----------------
   logic [BW-1:0]   busy_cnt;
   logic            busy;
   logic            acc_ins, acc_dw, acc_dr;
   logic            dd_set, cg_set;
   logic [AC_W-1:0] load_val;
   logic [AC_W-1:0] ac;
   logic            is_cg;
   ins_e            ins;

   assign busy    = (busy_cnt != '0);
   assign acc_ins = evt && (ex.kind == ACC_INS_WR) && !busy;
   assign acc_dw  = evt && (ex.kind == ACC_DAT_WR) && !busy;
   assign acc_dr  = evt && (ex.kind == ACC_DAT_RD);
   assign ins     = ins_class(ex.val);
   assign dd_set  = acc_ins && (ins == INS_DD_SET);
   assign cg_set  = acc_ins && (ins == INS_CG_SET);

   always_comb begin
      if (cg_set)
         load_val = AC_W'(ex.val[CG_AW-1:0]);
      else if (int'(ex.val[6:0]) < DD_DEPTH)
         load_val = AC_W'(ex.val[6:0]);
      else
         load_val = '0;
   end

   lcd_addr_ctr #(
      .AC_W     (AC_W),
      .DD_DEPTH (DD_DEPTH),
      .CG_DEPTH (CG_DEPTH)
   ) u_ac (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (dd_set || cg_set),
      .load_cg  (cg_set),
      .load_val (load_val),
      .step     (acc_dw || acc_dr),
      .up       (step_up),
      .ac       (ac),
      .is_cg    (is_cg)
   );

   // ---------------- stores ----------------
   logic [7:0] dd_rd, cg_rd;

   lcd_byte_ram #(.DEPTH(DD_DEPTH), .AW(DD_AW)) u_dd (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (acc_dw && !is_cg),
      .addr  (ac[DD_AW-1:0]),
      .wdata (ex.val),
      .rdata (dd_rd)
   );

   lcd_byte_ram #(.DEPTH(CG_DEPTH), .AW(CG_AW)) u_cg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (acc_dw && is_cg),
      .addr  (ac[CG_AW-1:0]),
      .wdata (ex.val),
      .rdata (cg_rd)
   );

   // ---------------- data register and busy timer ----------------
   logic [7:0] dr_q;
   logic       fetch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dr_q     <= '0;
         fetch_q  <= 1'b0;
         busy_cnt <= '0;
      end else begin
         fetch_q <= dd_set || cg_set || acc_dr;
         if (acc_dw)
            dr_q <= ex.val;
         else if (fetch_q)
            dr_q <= is_cg ? cg_rd : dd_rd;
         if (acc_ins || acc_dw)
            busy_cnt <= BW'(BUSY_CYCLES);
         else if (busy)
            busy_cnt <= busy_cnt - 1'b1;
      end
   end

   // ---------------- read mux ----------------
   logic [7:0] rd_byte;

   always_comb begin
      unique case (acc_e'({reg_sel, rd_wr}))
         ACC_STAT_RD: rd_byte = {busy, busy ? 7'd0 : 7'(ac)};
         ACC_DAT_RD:  rd_byte = dr_q;
         default:     rd_byte = 8'h00;
      endcase
      if (NIBBLE_EN && nibble_mode)
         bus_dout = low_next ? {rd_byte[3:0], 4'h0} : {rd_byte[7:4], 4'h0};
      else
         bus_dout = rd_byte;
   end

   // ---------------- assertions ----------------
   a_r3_busy_persists: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_cnt > BW'(1)) |=> busy);
   a_r3_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_ins || acc_dw) |=> busy);
   a_r3_dropped_write: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && ex.kind == ACC_DAT_WR && busy) |=> $stable(ac));
   a_r4_dd_load: assert property (@(posedge clk) disable iff (!rst_n)
      dd_set |=> (!is_cg && ac == $past(load_val)));
   a_r5_cg_load: assert property (@(posedge clk) disable iff (!rst_n)
      cg_set |=> (is_cg && ac == $past(load_val)));
   a_r12_other_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_ins && ins == INS_OTHER) |=> ($stable(ac) && $stable(is_cg)));

endmodule

// File: tb/lcd_host_if_test.sv
module lcd_host_if_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_stb = 1'b0;
   logic       reg_sel = 1'b0;
   logic       rd_wr = 1'b0;
   logic [7:0] bus_din = 8'h00;
   logic [7:0] bus_dout;
   logic       nibble_mode = 1'b0;
   logic       step_up = 1'b1;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   lcd_host_if uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_stb     (bus_stb),
      .reg_sel     (reg_sel),
      .rd_wr       (rd_wr),
      .bus_din     (bus_din),
      .bus_dout    (bus_dout),
      .nibble_mode (nibble_mode),
      .step_up     (step_up)
   );

   // ---------------- reference model ----------------
   int m_dd [80];
   int m_cg [64];
   int m_ac;
   bit m_tcg;
   int m_dr;

   function automatic void m_step();
      if (m_tcg)
         m_ac = step_up ? (m_ac + 1) & 63 : (m_ac + 63) & 63;
      else if (step_up)
         m_ac = (m_ac == 79) ? 0 : m_ac + 1;
      else
         m_ac = (m_ac == 0) ? 79 : m_ac - 1;
   endfunction

   function automatic int m_fetch();
      return m_tcg ? m_cg[m_ac] : m_dd[m_ac];
   endfunction

   function automatic void m_ins(input logic [7:0] b);
      if (b[7]) begin
         m_tcg = 1'b0;
         m_ac  = (int'(b[6:0]) <= 79) ? int'(b[6:0]) : 0;
         m_dr  = m_fetch();
      end else if (b[6]) begin
         m_tcg = 1'b1;
         m_ac  = int'(b[5:0]);
         m_dr  = m_fetch();
      end
   endfunction

   // ---------------- bus tasks ----------------
   task automatic chk(input int act, input int exp, input string req);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic strobe_once(input logic s, input logic w, input logic [7:0] v,
                              output logic [7:0] r);
      @(negedge clk);
      reg_sel = s; rd_wr = w; bus_din = v;
      @(negedge clk);
      bus_stb = 1'b1;
      repeat (4) @(negedge clk);
      r = bus_dout;
      bus_stb = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic xfer(input logic s, input logic w, input logic [7:0] v,
                       output logic [7:0] r);
      logic [7:0] hi, lo;
      if (nibble_mode) begin
         strobe_once(s, w, {v[7:4], 4'($urandom)}, hi);
         strobe_once(s, w, {v[3:0], 4'($urandom)}, lo);
         r = {hi[7:4], lo[7:4]};
      end else begin
         strobe_once(s, w, v, r);
      end
   endtask

   task automatic wait_idle();
      logic [7:0] s;
      s = 8'h80;
      for (int k = 0; k < 40; k++) begin
         xfer(1'b0, 1'b1, 8'h00, s);
         if (!s[7]) break;
      end
      chk(int'(s[7]), 0, "R3 busy clears");
      chk(int'(s[6:0]), m_ac, "R2 status address");
   endtask

   task automatic op_ins(input logic [7:0] b);
      logic [7:0] r;
      xfer(1'b0, 1'b0, b, r);
      m_ins(b);
      wait_idle();
   endtask

   task automatic op_wr(input logic [7:0] b);
      logic [7:0] r;
      xfer(1'b1, 1'b0, b, r);
      if (m_tcg) m_cg[m_ac] = int'(b); else m_dd[m_ac] = int'(b);
      m_dr = int'(b);
      m_step();
      wait_idle();
   endtask

   task automatic op_rd(input string req);
      logic [7:0] r;
      xfer(1'b1, 1'b1, 8'h00, r);
      chk(int'(r), m_dr, req);
      m_step();
      m_dr = m_fetch();
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [7:0] r;
      void'($urandom(32'd4242));
      for (int i = 0; i < 80; i++) m_dd[i] = 0;
      for (int i = 0; i < 64; i++) m_cg[i] = 0;
      m_ac = 0; m_tcg = 1'b0; m_dr = 0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R13: reset state through status and a data read
      xfer(1'b0, 1'b1, 8'h00, r);
      chk(int'(r), 8'h00, "R13 reset status");
      op_rd("R13 reset data register");

      // R4 / R6: write a few display bytes and read back (R7 prefetch)
      op_ins(8'h90);
      op_wr(8'hA5); op_wr(8'h5A); op_wr(8'hC3);
      op_ins(8'h90);
      op_rd("R7 first prefetched"); op_rd("R6 stored byte"); op_rd("R7 next fetched");

      // R3 / R2: status right after a write shows busy and masked address
      op_ins(8'h8A);
      xfer(1'b1, 1'b0, 8'h11, r);
      m_dd[m_ac] = 8'h11; m_dr = 8'h11; m_step();
      xfer(1'b0, 1'b1, 8'h00, r);
      chk(int'(r), 8'h80, "R2 R3 status while busy");
      wait_idle();

      // R3: a second data write inside the busy window is dropped
      op_ins(8'hA0);
      xfer(1'b1, 1'b0, 8'h77, r);
      xfer(1'b1, 1'b0, 8'h99, r);
      m_dd[m_ac] = 8'h77; m_dr = 8'h77; m_step();
      wait_idle();
      op_ins(8'hA0);
      op_rd("R3 kept first byte");
      op_rd("R3 dropped byte not stored");

      // R12: other instruction sets busy, keeps address
      op_ins(8'h87);
      xfer(1'b0, 1'b0, 8'h01, r);
      xfer(1'b0, 1'b1, 8'h00, r);
      chk(int'(r), 8'h80, "R12 other instruction busy");
      wait_idle();
      chk(m_ac, 7, "R12 address unchanged");

      // R4: out-of-range display address loads zero
      op_ins(8'hD5);
      chk(m_ac, 0, "R4 out-of-range set");

      // R8: display wrap both directions
      op_ins(8'hCF);
      op_wr(8'h4F);
      chk(m_ac, 0, "R8 wrap up");
      step_up = 1'b0;
      op_wr(8'h01);
      chk(m_ac, 79, "R8 wrap down");
      op_ins(8'hCF);
      op_rd("R8 byte at top after down-wrap");
      step_up = 1'b1;

      // R5 / R9: pattern store set and wrap
      op_ins(8'h7F);
      chk(int'(m_tcg), 1, "R5 pattern target");
      op_wr(8'h1F);
      chk(m_ac, 0, "R9 wrap up");
      step_up = 1'b0;
      op_wr(8'h0E);
      chk(m_ac, 63, "R9 wrap down");
      step_up = 1'b1;
      op_ins(8'h7F);
      op_rd("R5 pattern readback");

      // R10: 4-bit transfers
      nibble_mode = 1'b1;
      op_ins(8'hB0);
      op_wr(8'h3C);
      op_ins(8'hB0);
      op_rd("R10 nibble readback");

      // R11: stray half transfer, then a full-byte access realigns
      strobe_once(1'b0, 1'b0, 8'h90, r);
      nibble_mode = 1'b0;
      op_ins(8'h85);
      nibble_mode = 1'b1;
      xfer(1'b0, 1'b1, 8'h00, r);
      chk(int'(r), 8'h05, "R11 phase realigned");

      // random mix
      for (int n = 0; n < 300; n++) begin
         int pick;
         if (n % 50 == 0) nibble_mode = 1'($urandom);
         if (n % 37 == 0) step_up = 1'($urandom);
         pick = int'($urandom % 100);
         if (pick < 25) begin
            if ($urandom % 2) op_ins({1'b1, 7'($urandom % 80)});
            else op_ins({2'b01, 6'($urandom)});
         end else if (pick < 60) begin
            op_wr(8'($urandom));
         end else begin
            op_rd(nibble_mode ? "R10 random read" : "R7 random read");
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule